// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the byte-wide register front end for a bank of three interval counters. A host issues single-cycle read and write strobes with a 2-bit address and an 8-bit data bus. Addresses 0, 1 and 2 reach the data port of the matching counter. Address 3 is the control port. A control byte either configures one channel, freezes that channel's count for later reading, or issues a read-back command. A read-back command can freeze the count, the status, or both, on any subset of the channels at once.

For each channel the block keeps the access width, the counting mode and the decimal flag. It steps count writes and count reads through low byte only, high byte only, or low byte then high byte. Each completed write raises a one-cycle load strobe, together with the assembled 16-bit value for the counter. The counters themselves are outside the block. They supply their live count and output level as inputs, and they take mode, decimal flag and load strobes as outputs.

Top module: `timer_regif`

## Requirements
- R1: After reset every channel reports mode 0 and decimal flag 0, and its access width is low-then-high (3). No count or status is held, `rdata` is 0 and no load strobe is high.
- R2: A write to address 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero configures that channel. Bits 5:4 give the access width (1 = low byte only, 2 = high byte only, 3 = low then high), bits 3:1 give the mode and bit 0 gives the decimal flag. The new mode and flag appear on the outputs in the cycle after the strobe, and both byte sequencers of the channel restart at the low byte.
- R3: A mode field of 6 is stored as 2 and a mode field of 7 is stored as 3. Modes 0 to 5 are stored unchanged.
- R4: In low-only width a data write loads `{8'h00, data}`. In high-only width it loads `{data, 8'h00}`. The load strobe and value are valid in the cycle after the write strobe, and at most one channel loads per cycle.
- R5: In low-then-high width the first data write is held and produces no load. The second loads `{second, first}`. A configuring control write makes the next data write count as the first byte again.
- R6: With nothing frozen, a read returns the low byte of the live count in low-only width and the high byte in high-only width. In low-then-high width reads alternate between low and high, starting with low. `rdata` is updated one cycle after the read strobe and holds its value otherwise.
- R7: A control write with bits 5:4 = 0 freezes the channel's live count in that cycle. Later reads return the frozen value in the channel's access width. In low-then-high width they return the low byte, then the high byte, and after that the channel returns to live reads.
- R8: A count-freeze request for a channel that still holds an unread frozen count has no effect. The earlier value is the one that is read.
- R9: Bits 7:6 = 3 at address 3 form a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low requests a count freeze and bit 4 low requests a status freeze for every selected channel.
- R10: A frozen status byte holds the channel's output level in bit 7 and 0 in bit 6. Bits 5:4 hold the access width, bits 3:1 the mode and bit 0 the decimal flag, all taken in the cycle of the command.
- R11: When both a status and a count are frozen, the first read returns the status and the following reads return the count. A status-freeze request for a channel that still holds an unread status has no effect.
- R12: A read at address 3 returns 0 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Write data |
| ch_count | input | 48 | Live count of each channel, channel i at bits 16i+15:16i |
| ch_out | input | 3 | Output level of each channel |
| rdata | output | 8 | Registered read data |
| ch_mode | output | 9 | Mode of each channel, channel i at bits 3i+2:3i |
| ch_bcd | output | 3 | Decimal flag of each channel |
| ch_load | output | 3 | One-cycle load strobe per channel |
| ch_load_val | output | 48 | Value to load, channel i at bits 16i+15:16i |

## Verification
The bench goes after the orderings where the sequencers can fall out of step. It reconfigures between the two halves of a word write, which a design that fails to restart would finish with a stale low byte. It stacks a second count freeze on an unread one, which a careless design would let overwrite the first value. It also issues a read-back that freezes both status and count. A wrong priority there returns a count byte first, and a word-mode freeze that is never released keeps returning old data instead of the live count. Mode fields 6 and 7, the high-only shift and reads from the control port are each checked directly. Long random mixes of all commands against a bench-side model then catch drift between the write and read sequencers.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  // Modes 6 and 7 alias onto 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic [7:0] status_byte(input logic out_lvl, input acc_e acc,
                                             input logic [2:0] mode, input logic bcd);
    return {out_lvl, 1'b0, acc, mode, bcd};
  endfunction

  // Assemble the value handed to a counter on a completed write
  function automatic logic [15:0] load_word(input acc_e acc, input logic [7:0] held,
                                            input logic [7:0] data);
    case (acc)
      ACC_HI:   return {data, 8'h00};
      ACC_WORD: return {data, held};
      default:  return {8'h00, data};
    endcase
  endfunction

endpackage

// File: rtl/timer_regif_decode.sv
module timer_regif_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:1]        wbits,
  output logic [NUM_CH-1:0] cfg_set,
  output logic [NUM_CH-1:0] cnt_latch_req,
  output logic [NUM_CH-1:0] sts_latch_req,
  output logic [NUM_CH-1:0] data_wr,
  output logic [NUM_CH-1:0] rd_hit
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3);

  logic       ctrl_wr;
  logic       is_rb;
  logic [1:0] sel;
  logic       acc_zero;

  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign sel      = wbits[7:6];
  assign is_rb    = (sel == 2'd3);
  assign acc_zero = (wbits[5:4] == 2'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_sel;
    logic rb_sel;
    assign hit_sel          = ctrl_wr && !is_rb && (sel == 2'(i));
    assign rb_sel           = ctrl_wr && is_rb && wbits[1+i];
    assign cfg_set[i]       = hit_sel && !acc_zero;
    assign cnt_latch_req[i] = (hit_sel && acc_zero) || (rb_sel && !wbits[5]);
    assign sts_latch_req[i] = rb_sel && !wbits[4];
    assign data_wr[i]       = wr_en && (addr == ADDR_W'(i));
    assign rd_hit[i]        = rd_en && (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/timer_regif_chan.sv
module timer_regif_chan
  import timer_regif_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_set,
  input  logic [5:0]        cfg_bits,
  input  logic              cnt_latch_req,
  input  logic              sts_latch_req,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              rd_hit,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [DATA_W-1:0] rd_byte,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  localparam int HI_LSB = CNT_W - DATA_W;

  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q;
  logic              wr_hi_q;
  logic [DATA_W-1:0] hold_q;
  logic              rd_hi_q;
  acc_e              lat_q;
  logic [CNT_W-1:0]  lat_val_q;
  logic              sts_q;
  logic [7:0]        sts_val_q;
  logic              load_q;
  logic [CNT_W-1:0]  load_val_q;

  // Named internal events
  logic lat_busy, rd_sts, rd_lat, rd_live, wr_fire, take_cnt, take_sts;

  assign lat_busy = (lat_q != ACC_LATCH);
  assign rd_sts   = rd_hit && sts_q;
  assign rd_lat   = rd_hit && !sts_q && lat_busy;
  assign rd_live  = rd_hit && !sts_q && !lat_busy;
  assign wr_fire  = data_wr && ((acc_q != ACC_WORD) || wr_hi_q);
  assign take_cnt = cnt_latch_req && !lat_busy;
  assign take_sts = sts_latch_req && !sts_q;

  always_comb begin
    if (sts_q) begin
      rd_byte = sts_val_q;
    end else if (lat_busy) begin
      rd_byte = (lat_q == ACC_HI) ? lat_val_q[CNT_W-1:HI_LSB] : lat_val_q[DATA_W-1:0];
    end else begin
      case (acc_q)
        ACC_HI:   rd_byte = live_cnt[CNT_W-1:HI_LSB];
        ACC_WORD: rd_byte = rd_hi_q ? live_cnt[CNT_W-1:HI_LSB] : live_cnt[DATA_W-1:0];
        default:  rd_byte = live_cnt[DATA_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      hold_q     <= '0;
      rd_hi_q    <= 1'b0;
      lat_q      <= ACC_LATCH;
      lat_val_q  <= '0;
      sts_q      <= 1'b0;
      sts_val_q  <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      if (cfg_set) begin
        acc_q   <= acc_e'(cfg_bits[5:4]);
        mode_q  <= fold_mode(cfg_bits[3:1]);
        bcd_q   <= cfg_bits[0];
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end else begin
        if (data_wr && (acc_q == ACC_WORD)) begin
          wr_hi_q <= !wr_hi_q;
          if (!wr_hi_q) hold_q <= data_byte;
        end
        if (rd_live && (acc_q == ACC_WORD)) rd_hi_q <= !rd_hi_q;
      end

      if (take_cnt) begin
        lat_q     <= acc_q;
        lat_val_q <= live_cnt;
      end else if (rd_lat) begin
        lat_q <= (lat_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
      end

      if (take_sts) begin
        sts_q     <= 1'b1;
        sts_val_q <= status_byte(out_lvl, acc_q, mode_q, bcd_q);
      end else if (rd_sts) begin
        sts_q <= 1'b0;
      end

      load_q <= wr_fire;
      if (wr_fire) load_val_q <= load_word(acc_q, hold_q, data_byte);
    end
  end

  assign mode     = mode_q;
  assign bcd      = bcd_q;
  assign load     = load_q;
  assign load_val = load_val_q;

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sts_q) |=> (!sts_q && $stable(lat_q)));                         // R11
  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_busy && $past(lat_busy)) |-> $stable(lat_val_q));                      // R7
  AST_RELATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_latch_req && lat_busy) |=> $stable(lat_val_q));                        // R8
  AST_FIRST_HALF_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (acc_q == ACC_WORD) && !wr_hi_q) |=> !load_q);                  // R5

endmodule

// File: rtl/timer_regif.sv
module timer_regif
  import timer_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NUM_CH*CNT_W-1:0] ch_count,
  input  logic [NUM_CH-1:0]       ch_out,
  output logic [DATA_W-1:0]       rdata,
  output logic [NUM_CH*3-1:0]     ch_mode,
  output logic [NUM_CH-1:0]       ch_bcd,
  output logic [NUM_CH-1:0]       ch_load,
  output logic [NUM_CH*CNT_W-1:0] ch_load_val
);
  logic [NUM_CH-1:0] cfg_set, cnt_latch_req, sts_latch_req, data_wr, rd_hit;
  logic [DATA_W-1:0] rd_byte [NUM_CH];
  logic [DATA_W-1:0] rsel;
  logic [DATA_W-1:0] rdata_q;

  timer_regif_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wbits         (wdata[7:1]),
    .cfg_set       (cfg_set),
    .cnt_latch_req (cnt_latch_req),
    .sts_latch_req (sts_latch_req),
    .data_wr       (data_wr),
    .rd_hit        (rd_hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    timer_regif_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_set       (cfg_set[i]),
      .cfg_bits      (wdata[5:0]),
      .cnt_latch_req (cnt_latch_req[i]),
      .sts_latch_req (sts_latch_req[i]),
      .data_wr       (data_wr[i]),
      .data_byte     (wdata),
      .rd_hit        (rd_hit[i]),
      .live_cnt      (ch_count[i*CNT_W +: CNT_W]),
      .out_lvl       (ch_out[i]),
      .rd_byte       (rd_byte[i]),
      .mode          (ch_mode[i*3 +: 3]),
      .bcd           (ch_bcd[i]),
      .load          (ch_load[i]),
      .load_val      (ch_load_val[i*CNT_W +: CNT_W])
    );
  end

  // Control address and unused codes read as zero
  always_comb begin
    rsel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rsel = rd_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rsel;
  end

  assign rdata = rdata_q;

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));                                                        // R4
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));                                          // R6

endmodule

// File: tb/timer_regif_tb.sv
module timer_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [47:0] ch_count = '0;
  logic [2:0]  ch_out = '0;
  logic [7:0]  rdata;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd, ch_load;
  logic [47:0] ch_load_val;

  int nchk = 0, nerr = 0;

  // Bench-side model of each channel, built from the requirements
  int          m_acc [3], m_mode [3], m_bcd [3];
  int          m_wrhi [3], m_rdhi [3], m_lat [3], m_sts [3];
  logic [7:0]  m_hold [3], m_stsv [3];
  logic [15:0] m_latv [3];

  timer_regif u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ch_count(ch_count), .ch_out(ch_out), .rdata(rdata),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load(ch_load), .ch_load_val(ch_load_val)
  );

  always #10 clk = ~clk;

  function automatic int exp_fold(input int m);
    return (m > 5) ? m - 4 : m;
  endfunction

  function automatic logic [7:0] exp_status(input int o, input int a, input int m, input int b);
    return 8'(o * 128 + a * 16 + m * 2 + b);
  endfunction

  function automatic logic [15:0] cnt_of(input int ch);
    return ch_count[ch*16 +: 16];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_acc[i] = 3; m_mode[i] = 0; m_bcd[i] = 0; m_wrhi[i] = 0; m_rdhi[i] = 0;
      m_lat[i] = 0; m_sts[i] = 0; m_hold[i] = 0; m_stsv[i] = 0; m_latv[i] = 0;
    end
  endtask

  task automatic freeze_cnt(input int i);
    if (m_lat[i] == 0) begin m_lat[i] = m_acc[i]; m_latv[i] = cnt_of(i); end
  endtask

  task automatic do_ctrl(input logic [7:0] b, input string tag);
    int sel = int'(b[7:6]);
    if (sel == 3) begin
      for (int i = 0; i < 3; i++) begin
        if (b[1+i]) begin
          if (!b[5]) freeze_cnt(i);
          if (!b[4] && m_sts[i] == 0) begin
            m_sts[i] = 1;
            m_stsv[i] = exp_status(int'(ch_out[i]), m_acc[i], m_mode[i], m_bcd[i]);
          end
        end
      end
    end else if (b[5:4] == 2'd0) begin
      freeze_cnt(sel);
    end else begin
      m_acc[sel] = int'(b[5:4]); m_mode[sel] = exp_fold(int'(b[3:1]));
      m_bcd[sel] = int'(b[0]); m_wrhi[sel] = 0; m_rdhi[sel] = 0;
    end
    wr_en = 1'b1; addr = 2'd3; wdata = b;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(int'(ch_mode[i*3 +: 3]) == m_mode[i], tag, int'(ch_mode[i*3 +: 3]), m_mode[i]);
      check(int'(ch_bcd[i]) == m_bcd[i], tag, int'(ch_bcd[i]), m_bcd[i]);
    end
    check(ch_load == 3'b000, tag, int'(ch_load), 0);
  endtask

  task automatic do_write(input int ch, input logic [7:0] d, input string tag);
    bit fire = 1'b1;
    logic [15:0] v = 16'(d);
    if (m_acc[ch] == 2) v = {d, 8'h00};
    if (m_acc[ch] == 3) begin
      if (m_wrhi[ch] == 0) begin fire = 1'b0; m_hold[ch] = d; m_wrhi[ch] = 1; end
      else begin v = {d, m_hold[ch]}; m_wrhi[ch] = 0; end
    end
    wr_en = 1'b1; addr = 2'(ch); wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    check(ch_load == (fire ? 3'(1 << ch) : 3'b000), tag, int'(ch_load), fire ? (1 << ch) : 0);
    if (fire) check(ch_load_val[ch*16 +: 16] == v, tag, int'(ch_load_val[ch*16 +: 16]), int'(v));
  endtask

  task automatic do_read(input int ch, input string tag);
    logic [7:0] e = 8'h00;
    if (ch < 3) begin
      if (m_sts[ch] != 0) begin
        e = m_stsv[ch]; m_sts[ch] = 0;
      end else if (m_lat[ch] != 0) begin
        e = (m_lat[ch] == 2) ? m_latv[ch][15:8] : m_latv[ch][7:0];
        m_lat[ch] = (m_lat[ch] == 3) ? 2 : 0;
      end else if (m_acc[ch] == 2) begin
        e = cnt_of(ch)[15:8];
      end else if (m_acc[ch] == 3) begin
        e = m_rdhi[ch] != 0 ? cnt_of(ch)[15:8] : cnt_of(ch)[7:0];
        m_rdhi[ch] = 1 - m_rdhi[ch];
      end else begin
        e = cnt_of(ch)[7:0];
      end
    end
    rd_en = 1'b1; addr = 2'(ch);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check(rdata == e, tag, int'(rdata), int'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int seed = 20240611;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ch_mode == 9'd0, "R1 mode", int'(ch_mode), 0);
    check(ch_bcd == 3'd0, "R1 bcd", int'(ch_bcd), 0);
    check(ch_load == 3'd0, "R1 load", int'(ch_load), 0);
    check(rdata == 8'd0, "R1 rdata", int'(rdata), 0);

    // R2 configuration, R3 folding
    do_ctrl(8'h14, "R2 ch0 low-only mode2");
    do_ctrl(8'h7F, "R3 ch1 word mode7->3 bcd");
    do_ctrl(8'hAC, "R3 ch2 high-only mode6->2");

    // R4 single-byte loads, R5 word loads
    do_write(0, 8'h5A, "R4 low-only load");
    do_write(2, 8'h33, "R4 high-only load");
    do_write(1, 8'h34, "R5 first half held");
    do_write(1, 8'h12, "R5 word load");
    do_write(1, 8'h77, "R5 half before reconfig");
    do_ctrl(8'h76, "R2 ch1 reconfig word");
    do_write(1, 8'hAB, "R5 restart low");
    do_write(1, 8'hCD, "R5 restart high");

    // R6 live reads
    ch_count = {16'hC3D4, 16'hA1B2, 16'h9F8E};
    do_read(1, "R6 word low"); do_read(1, "R6 word high"); do_read(1, "R6 word low again");
    do_read(0, "R6 low-only"); do_read(2, "R6 high-only");

    // R7 count freeze in word width, then release
    do_ctrl(8'h40, "R7 freeze ch1");
    ch_count[31:16] = 16'h0F0E;
    do_read(1, "R7 frozen low"); do_read(1, "R7 frozen high"); do_read(1, "R7 live after release");

    // R8 second freeze ignored
    do_ctrl(8'h00, "R8 freeze ch0");
    ch_count[15:0] = 16'h1357;
    do_ctrl(8'h00, "R8 refreeze ch0");
    do_read(0, "R8 first value kept"); do_read(0, "R8 live after");

    // R9 read-back on all channels, R10 status layout, R11 ordering
    ch_out = 3'b101;
    do_ctrl(8'hCE, "R9 readback count+status");
    ch_count = {16'h1111, 16'h2222, 16'h3333};
    do_read(1, "R10 status ch1"); do_read(1, "R11 count low after status");
    do_read(1, "R11 count high"); do_read(0, "R10 status ch0");
    do_read(0, "R11 count ch0"); do_read(2, "R10 status ch2"); do_read(2, "R11 count ch2");
    do_ctrl(8'hE2, "R9 status only ch0");
    ch_out = 3'b000;
    do_ctrl(8'hE2, "R11 status refreeze ignored");
    do_read(0, "R11 first status kept"); do_read(0, "R9 live after status");
    do_ctrl(8'hDA, "R9 count only ch0 ch2");
    do_read(2, "R9 frozen ch2");

    // R12 control-port read
    do_read(3, "R12 control read zero");
    do_read(2, "R12 state untouched");

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int op = int'($urandom_range(0, 9));
      int ch = int'($urandom_range(0, 2));
      ch_count = {$urandom(), $urandom()} >> 16;
      ch_out = 3'($urandom());
      if (op < 2)      do_ctrl(8'($urandom()), "R2 random control");
      else if (op < 3) do_ctrl({2'b11, 6'($urandom())}, "R9 random readback");
      else if (op < 6) do_write(ch, 8'($urandom()), "R5 random write");
      else             do_read(int'($urandom_range(0, 3)), "R6 random read");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule